// File: doc/BRIEF.md
# Windowed Return and Underflow Unit

This unit settles the register-window side of a windowed return, the two returns from a window trap handler, and a windowed call. It does not hold the window state itself. The core presents the current window base, the window-start vector, the overflow-enable and exception-mode flags, the saved window base, the trap PC and the instruction's operands, along with a request. One cycle later the unit returns the next value of each of those fields, the jump target, and a classification of the outcome. The surrounding core then writes those values back.

For a return, the call size is taken from the two top bits of the return address held in logical register 0. The unit searches the window-start vector just below the current base to find the caller's frame size, and uses the two values to decide between three outcomes:

- an illegal return;
- a normal return, which rotates the window and frees the callee frame;
- a window underflow, which rotates the window, saves the old base, enters exception mode and names one of three underflow handlers.

The two trap-return operations restore the saved base, leave exception mode and mark the current frame as freed or as live. A call produces the link word and the register index it goes to. Filling registers from memory is left to the trap handlers.

Top module: `winret_unit`

## Requirements
- R1: The operation code `req_op` is 2'b00 windowed return, 2'b01 return from overflow handler, 2'b10 return from underflow handler, 2'b11 windowed call. On a normal return, `rsp_jump` is 1 and `rsp_target` is {`req_pc`[PC_W-1:PC_W-2], `req_ret_addr`[PC_W-3:0]}, where the call size n is `req_ret_addr`[PC_W-1:PC_W-2].
- R2: The caller size m is 1, 2 or 3 for the first set bit of `wstart_i` at index base-1, then base-2, then base-3 (modulo NUM_WIN), searched in that order. m is 0 when none of the three bits is set.
- R3: A return is illegal when n = 0, when m ≠ 0 and m ≠ n, when `ovf_en_i` is 0, or when `exc_mode_i` is 1. An illegal return raises `rsp_illegal`, returns the base, start vector, exception mode and saved base unchanged, and gives no jump and no trap-PC write.
- R4: On a legal return where the start bit at base-n (mod NUM_WIN) is set, the new base is base-n and the start bit at the old base is cleared.
- R5: On a legal return where the start bit at base-n is clear, the unit signals an underflow. It raises `rsp_underflow`, sets `rsp_uf_kind` = n (1/2/3 select the 4/8/12-register handler), sets the new base to base-n, stores the old base in `rsp_saved_base`, sets exception mode, writes `req_pc` as the trap PC, leaves the start vector unchanged and gives no jump.
- R6: Return from overflow clears the start bit at the current base. Return from underflow sets it.
- R7: Both trap returns clear exception mode, set the base to `saved_base_i` and jump to `trap_pc_i`.
- R8: A call with size c = `req_call_inc` gives `rsp_link` = (c << (PC_W-2)) | ((`req_pc`+3) mod 2^(PC_W-2)), `rsp_link_idx` = 4c and `rsp_callinc` = c, with their write strobes raised.
- R9: Results appear on the clock edge after the request, with `rsp_valid` high. `rsp_illegal` and `rsp_underflow` are never both set. With no request, `rsp_valid` and every flag and strobe are 0.
- R10: After reset, `rsp_valid`, `rsp_illegal`, `rsp_underflow` and `rsp_jump` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (R1) |
| req_pc | input | PC_W | PC of the instruction |
| req_ret_addr | input | PC_W | Logical register 0 (return address) |
| req_call_inc | input | 2 | Call size for a call |
| wbase_i | input | log2(NUM_WIN) | Current window base |
| wstart_i | input | NUM_WIN | Current window-start vector |
| ovf_en_i | input | 1 | Window overflow enable |
| exc_mode_i | input | 1 | Exception mode flag |
| saved_base_i | input | log2(NUM_WIN) | Saved old window base |
| trap_pc_i | input | PC_W | Saved trap PC |
| rsp_valid | output | 1 | Result valid |
| rsp_illegal | output | 1 | Illegal return |
| rsp_underflow | output | 1 | Window underflow |
| rsp_uf_kind | output | 2 | Underflow handler select (n) |
| rsp_jump | output | 1 | Jump to rsp_target |
| rsp_target | output | PC_W | Jump target |
| rsp_wbase | output | log2(NUM_WIN) | Next window base |
| rsp_wstart | output | NUM_WIN | Next window-start vector |
| rsp_exc_mode | output | 1 | Next exception mode |
| rsp_saved_base | output | log2(NUM_WIN) | Next saved window base |
| rsp_trap_we | output | 1 | Trap PC write strobe |
| rsp_trap_pc | output | PC_W | Next trap PC |
| rsp_link_we | output | 1 | Link register write strobe |
| rsp_link_idx | output | 4 | Logical register index for the link |
| rsp_link | output | PC_W | Link word |
| rsp_callinc_we | output | 1 | Call-increment write strobe |
| rsp_callinc | output | 2 | Call-increment value |

## Verification
Illegality and underflow are both decided from the same return in the same cycle, so one request can meet the conditions for both. The bench provokes this with a return whose rotated base has its start bit clear while overflow-enable is off, or while exception mode is set. It then expects only `rsp_illegal`, with `rsp_underflow` low and all architectural state returned unchanged. The opposite case is also driven: the caller-size search finds a frame whose size differs from n. The bench checks that the mismatch wins over a normal return.

// File: rtl/winret_pkg.sv
package winret_pkg;
   typedef enum logic [1:0] {
      OP_RET  = 2'b00,
      OP_RFWO = 2'b01,
      OP_RFWU = 2'b10,
      OP_CALL = 2'b11
   } winret_op_e;

   localparam int unsigned PROBE_DEPTH = 3;
endpackage

// File: rtl/winret_bit_pick.sv
module winret_bit_pick #(
   parameter int unsigned NUM_WIN = 16,
   localparam int unsigned WB_W = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0] vec_i,
   input  logic [WB_W-1:0]    idx_i,
   output logic               bit_o,
   output logic [NUM_WIN-1:0] mask_o
);
   for (genvar g = 0; g < NUM_WIN; g++) begin : g_dec
      assign mask_o[g] = (idx_i == WB_W'(g));
   end
   assign bit_o = |(vec_i & mask_o);
endmodule

// File: rtl/winret_caller_probe.sv
module winret_caller_probe import winret_pkg::*; #(
   parameter int unsigned NUM_WIN = 16,
   localparam int unsigned WB_W = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0] wstart_i,
   input  logic [WB_W-1:0]    wbase_i,
   output logic [1:0]         caller_sz_o
);
   logic [PROBE_DEPTH:1] hit;

   for (genvar k = 1; k <= PROBE_DEPTH; k++) begin : g_probe
      logic [WB_W-1:0] idx;
      logic            unused_mask_ok;
      logic [NUM_WIN-1:0] mask;
      assign idx = wbase_i - WB_W'(k);
      winret_bit_pick #(.NUM_WIN(NUM_WIN)) i_pick (
         .vec_i  (wstart_i),
         .idx_i  (idx),
         .bit_o  (hit[k]),
         .mask_o (mask)
      );
      assign unused_mask_ok = |mask;
   end

   always_comb begin
      caller_sz_o = 2'd0;
      for (int k = PROBE_DEPTH; k >= 1; k--) begin
         if (hit[k]) caller_sz_o = 2'(k);
      end
   end
endmodule

// File: rtl/winret_unit.sv
module winret_unit import winret_pkg::*; #(
   parameter int unsigned NUM_WIN = 16,
   parameter int unsigned PC_W    = 32,
   localparam int unsigned WB_W   = $clog2(NUM_WIN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [PC_W-1:0]    req_pc,
   input  logic [PC_W-1:0]    req_ret_addr,
   input  logic [1:0]         req_call_inc,
   input  logic [WB_W-1:0]    wbase_i,
   input  logic [NUM_WIN-1:0] wstart_i,
   input  logic               ovf_en_i,
   input  logic               exc_mode_i,
   input  logic [WB_W-1:0]    saved_base_i,
   input  logic [PC_W-1:0]    trap_pc_i,
   output logic               rsp_valid,
   output logic               rsp_illegal,
   output logic               rsp_underflow,
   output logic [1:0]         rsp_uf_kind,
   output logic               rsp_jump,
   output logic [PC_W-1:0]    rsp_target,
   output logic [WB_W-1:0]    rsp_wbase,
   output logic [NUM_WIN-1:0] rsp_wstart,
   output logic               rsp_exc_mode,
   output logic [WB_W-1:0]    rsp_saved_base,
   output logic               rsp_trap_we,
   output logic [PC_W-1:0]    rsp_trap_pc,
   output logic               rsp_link_we,
   output logic [3:0]         rsp_link_idx,
   output logic [PC_W-1:0]    rsp_link,
   output logic               rsp_callinc_we,
   output logic [1:0]         rsp_callinc
);
   localparam int unsigned LOW_W = PC_W - 2;

   if (NUM_WIN < 4 || (NUM_WIN & (NUM_WIN - 1)) != 0) begin : g_bad_win
      $error("winret_unit: NUM_WIN must be a power of two of at least 4");
   end
   if (PC_W < 8) begin : g_bad_pc
      $error("winret_unit: PC_W must be at least 8");
   end

   winret_op_e         op;
   logic [1:0]         call_sz;
   logic [1:0]         caller_sz;
   logic [WB_W-1:0]    back_base;
   logic               back_live;
   logic [NUM_WIN-1:0] back_mask;
   logic               cur_live;
   logic [NUM_WIN-1:0] cur_mask;
   logic               bad_ret;

   assign op      = winret_op_e'(req_op);
   assign call_sz = req_ret_addr[PC_W-1 -: 2];
   assign back_base = wbase_i - WB_W'(call_sz);

   winret_caller_probe #(.NUM_WIN(NUM_WIN)) i_probe (
      .wstart_i    (wstart_i),
      .wbase_i     (wbase_i),
      .caller_sz_o (caller_sz)
   );

   winret_bit_pick #(.NUM_WIN(NUM_WIN)) i_back_pick (
      .vec_i  (wstart_i),
      .idx_i  (back_base),
      .bit_o  (back_live),
      .mask_o (back_mask)
   );

   winret_bit_pick #(.NUM_WIN(NUM_WIN)) i_cur_pick (
      .vec_i  (wstart_i),
      .idx_i  (wbase_i),
      .bit_o  (cur_live),
      .mask_o (cur_mask)
   );

   assign bad_ret = (call_sz == 2'd0)
                  || (caller_sz != 2'd0 && caller_sz != call_sz)
                  || !ovf_en_i || exc_mode_i;

   logic               n_illegal, n_underflow, n_jump, n_exc, n_trap_we;
   logic               n_link_we, n_callinc_we;
   logic [1:0]         n_uf_kind, n_callinc;
   logic [PC_W-1:0]    n_target, n_trap_pc, n_link;
   logic [WB_W-1:0]    n_wbase, n_saved;
   logic [NUM_WIN-1:0] n_wstart;
   logic [3:0]         n_link_idx;
   logic [PC_W-1:0]    pc_plus3;

   assign pc_plus3 = req_pc + PC_W'(3);

   always_comb begin
      n_illegal    = 1'b0;
      n_underflow  = 1'b0;
      n_uf_kind    = 2'd0;
      n_jump       = 1'b0;
      n_target     = '0;
      n_wbase      = wbase_i;
      n_wstart     = wstart_i;
      n_exc        = exc_mode_i;
      n_saved      = saved_base_i;
      n_trap_we    = 1'b0;
      n_trap_pc    = trap_pc_i;
      n_link_we    = 1'b0;
      n_link_idx   = 4'd0;
      n_link       = '0;
      n_callinc_we = 1'b0;
      n_callinc    = 2'd0;
      unique case (op)
         OP_RET: begin
            if (bad_ret) begin
               n_illegal = 1'b1;
            end else begin
               n_wbase = back_base;
               if (back_live) begin
                  n_wstart = wstart_i & ~cur_mask;
                  n_jump   = 1'b1;
                  n_target = {req_pc[PC_W-1 -: 2], req_ret_addr[LOW_W-1:0]};
               end else begin
                  n_underflow = 1'b1;
                  n_uf_kind   = call_sz;
                  n_saved     = wbase_i;
                  n_exc       = 1'b1;
                  n_trap_we   = 1'b1;
                  n_trap_pc   = req_pc;
               end
            end
         end
         OP_RFWO, OP_RFWU: begin
            n_wstart = (op == OP_RFWO) ? (wstart_i & ~cur_mask)
                                       : (wstart_i | cur_mask);
            n_exc    = 1'b0;
            n_wbase  = saved_base_i;
            n_jump   = 1'b1;
            n_target = trap_pc_i;
         end
         OP_CALL: begin
            n_link_we    = 1'b1;
            n_link_idx   = {req_call_inc, 2'b00};
            n_link       = {req_call_inc, pc_plus3[LOW_W-1:0]};
            n_callinc_we = 1'b1;
            n_callinc    = req_call_inc;
         end
         default: ;
      endcase
   end

   logic unused_ok;
   assign unused_ok = cur_live | (|back_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_illegal    <= 1'b0;
         rsp_underflow  <= 1'b0;
         rsp_uf_kind    <= 2'd0;
         rsp_jump       <= 1'b0;
         rsp_target     <= '0;
         rsp_wbase      <= '0;
         rsp_wstart     <= '0;
         rsp_exc_mode   <= 1'b0;
         rsp_saved_base <= '0;
         rsp_trap_we    <= 1'b0;
         rsp_trap_pc    <= '0;
         rsp_link_we    <= 1'b0;
         rsp_link_idx   <= 4'd0;
         rsp_link       <= '0;
         rsp_callinc_we <= 1'b0;
         rsp_callinc    <= 2'd0;
      end else begin
         rsp_valid      <= req_valid;
         rsp_illegal    <= req_valid & n_illegal;
         rsp_underflow  <= req_valid & n_underflow;
         rsp_jump       <= req_valid & n_jump;
         rsp_trap_we    <= req_valid & n_trap_we;
         rsp_link_we    <= req_valid & n_link_we;
         rsp_callinc_we <= req_valid & n_callinc_we;
         if (req_valid) begin
            rsp_uf_kind    <= n_uf_kind;
            rsp_target     <= n_target;
            rsp_wbase      <= n_wbase;
            rsp_wstart     <= n_wstart;
            rsp_exc_mode   <= n_exc;
            rsp_saved_base <= n_saved;
            rsp_trap_pc    <= n_trap_pc;
            rsp_link_idx   <= n_link_idx;
            rsp_link       <= n_link;
            rsp_callinc    <= n_callinc;
         end
      end
   end
endmodule

// File: rtl/winret_chk.sv
module winret_chk import winret_pkg::*; #(
   parameter int unsigned NUM_WIN = 16,
   parameter int unsigned PC_W    = 32,
   localparam int unsigned WB_W   = $clog2(NUM_WIN)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [1:0]         req_op,
   input logic [PC_W-1:0]    req_ret_addr,
   input logic [1:0]         req_call_inc,
   input logic [WB_W-1:0]    saved_base_i,
   input logic [PC_W-1:0]    trap_pc_i,
   input logic               rsp_valid,
   input logic               rsp_illegal,
   input logic               rsp_underflow,
   input logic [1:0]         rsp_uf_kind,
   input logic               rsp_jump,
   input logic [PC_W-1:0]    rsp_target,
   input logic [WB_W-1:0]    rsp_wbase,
   input logic               rsp_exc_mode,
   input logic               rsp_trap_we,
   input logic               rsp_link_we,
   input logic [3:0]         rsp_link_idx
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R9
   AST_RSP_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_illegal && !rsp_underflow && !rsp_jump
                     && !rsp_trap_we && !rsp_link_we); // R9
   AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_illegal, rsp_underflow})); // R9
   AST_ZERO_SIZE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_RET && req_ret_addr[PC_W-1 -: 2] == 2'd0)
      |=> rsp_illegal); // R3
   AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> !rsp_jump && !rsp_trap_we); // R3
   AST_UNDERFLOW_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_underflow |-> rsp_exc_mode && rsp_trap_we && !rsp_jump
                        && rsp_uf_kind != 2'd0); // R5
   AST_RFW_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == OP_RFWO || req_op == OP_RFWU))
      |=> rsp_jump && !rsp_exc_mode && rsp_wbase == $past(saved_base_i)
          && rsp_target == $past(trap_pc_i)); // R7
   AST_CALL_LINK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_CALL)
      |=> rsp_link_we && rsp_link_idx == {$past(req_call_inc), 2'b00}); // R8
endmodule

bind winret_unit winret_chk #(.NUM_WIN(NUM_WIN), .PC_W(PC_W)) i_winret_chk (.*);

// File: tb/test_winret_unit.sv
module test_winret_unit;
   import winret_pkg::*;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NUM_WIN = 16;
   localparam int unsigned PC_W = 32;
   localparam int unsigned WB_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [PC_W-1:0] req_pc = '0, req_ret_addr = '0, trap_pc_i = '0;
   logic [1:0] req_call_inc = 2'd0;
   logic [WB_W-1:0] wbase_i = '0, saved_base_i = '0;
   logic [NUM_WIN-1:0] wstart_i = '0;
   logic ovf_en_i = 1'b0, exc_mode_i = 1'b0;

   logic rsp_valid, rsp_illegal, rsp_underflow, rsp_jump, rsp_exc_mode;
   logic rsp_trap_we, rsp_link_we, rsp_callinc_we;
   logic [1:0] rsp_uf_kind, rsp_callinc;
   logic [PC_W-1:0] rsp_target, rsp_trap_pc, rsp_link;
   logic [WB_W-1:0] rsp_wbase, rsp_saved_base;
   logic [NUM_WIN-1:0] rsp_wstart;
   logic [3:0] rsp_link_idx;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   winret_unit #(.NUM_WIN(NUM_WIN), .PC_W(PC_W)) i_winret_unit (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic fire(input logic [1:0] op);
      req_op = op;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_ret(input logic [31:0] pc, input logic [31:0] ra, input logic [3:0] base,
                         input logic [15:0] start, input logic ovf, input logic exc,
                         input logic [3:0] saved);
      req_pc = pc; req_ret_addr = ra; wbase_i = base; wstart_i = start;
      ovf_en_i = ovf; exc_mode_i = exc; saved_base_i = saved; trap_pc_i = 32'h0BAD_0000;
      fire(OP_RET);
   endtask

   task automatic expect_out(input string tag, input logic ill, input logic uf, input logic [1:0] kind,
                             input logic jmp, input logic [31:0] tgt, input logic [3:0] base,
                             input logic [15:0] start, input logic exc, input logic [3:0] saved,
                             input logic twe, input logic [31:0] tpc);
      chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
      chk({tag, " illegal"}, 32'(rsp_illegal), 32'(ill));
      chk({tag, " underflow"}, 32'(rsp_underflow), 32'(uf));
      if (uf) chk({tag, " uf_kind"}, 32'(rsp_uf_kind), 32'(kind));
      chk({tag, " jump"}, 32'(rsp_jump), 32'(jmp));
      if (jmp) chk({tag, " target"}, rsp_target, tgt);
      chk({tag, " wbase"}, 32'(rsp_wbase), 32'(base));
      chk({tag, " wstart"}, 32'(rsp_wstart), 32'(start));
      chk({tag, " exc_mode"}, 32'(rsp_exc_mode), 32'(exc));
      chk({tag, " saved_base"}, 32'(rsp_saved_base), 32'(saved));
      chk({tag, " trap_we"}, 32'(rsp_trap_we), 32'(twe));
      chk({tag, " trap_pc"}, rsp_trap_pc, tpc);
   endtask

   task automatic t_reset();
      chk("R10 reset valid", 32'(rsp_valid), 32'd0);
      chk("R10 reset illegal", 32'(rsp_illegal), 32'd0);
      chk("R10 reset underflow", 32'(rsp_underflow), 32'd0);
      chk("R10 reset jump", 32'(rsp_jump), 32'd0);
   endtask

   task automatic t_normal();
      // R1 R4: n=1, base 5, frames at 4 and 5
      do_ret(32'h8000_1234, 32'h4000_5678, 4'd5, 16'h0030, 1'b1, 1'b0, 4'd9);
      expect_out("R1_R4 n1", 0, 0, 0, 1, 32'h8000_5678, 4'd4, 16'h0010, 0, 4'd9, 0, 32'h0BAD_0000);
      // R2 R4: n=2, base wraps 0 -> 14, probe skips 15, finds 14
      do_ret(32'h0000_0040, 32'h8000_0100, 4'd0, 16'h4001, 1'b1, 1'b0, 4'd1);
      expect_out("R2_R4 wrap", 0, 0, 0, 1, 32'h0000_0100, 4'd14, 16'h4000, 0, 4'd1, 0, 32'h0BAD_0000);
   endtask

   task automatic t_underflow();
      // R5: n=3, no caller frame, start at base 0 clear
      do_ret(32'h1000_0000, 32'hC000_0200, 4'd3, 16'h0008, 1'b1, 1'b0, 4'd7);
      expect_out("R5 uf12", 0, 1, 2'd3, 0, 0, 4'd0, 16'h0008, 1, 4'd3, 1, 32'h1000_0000);
      do_ret(32'h2222_0000, 32'h4000_0000, 4'd8, 16'h0100, 1'b1, 1'b0, 4'd0);
      expect_out("R5 uf4", 0, 1, 2'd1, 0, 0, 4'd7, 16'h0100, 1, 4'd8, 1, 32'h2222_0000);
   endtask

   task automatic t_illegal();
      do_ret(32'h0, 32'h0000_1000, 4'd5, 16'h0030, 1'b1, 1'b0, 4'd2);
      expect_out("R3 n0", 1, 0, 0, 0, 0, 4'd5, 16'h0030, 0, 4'd2, 0, 32'h0BAD_0000);
      // R2 R3: frames at 3 and 4, base-1 wins so m=1, n=2 mismatches
      do_ret(32'h0, 32'h8000_0000, 4'd5, 16'h0038, 1'b1, 1'b0, 4'd2);
      expect_out("R2_R3 mismatch", 1, 0, 0, 0, 0, 4'd5, 16'h0038, 0, 4'd2, 0, 32'h0BAD_0000);
      do_ret(32'h0, 32'h4000_0000, 4'd5, 16'h0038, 1'b1, 1'b0, 4'd2);
      expect_out("R2 match m1", 0, 0, 0, 1, 32'h0000_0000, 4'd4, 16'h0018, 0, 4'd2, 0, 32'h0BAD_0000);
      // R3 R9: underflow conditions but overflow-enable clear -> illegal only
      do_ret(32'h0, 32'hC000_0200, 4'd3, 16'h0008, 1'b0, 1'b0, 4'd7);
      expect_out("R3_R9 ovf off", 1, 0, 0, 0, 0, 4'd3, 16'h0008, 0, 4'd7, 0, 32'h0BAD_0000);
      do_ret(32'h0, 32'hC000_0200, 4'd3, 16'h0008, 1'b1, 1'b1, 4'd7);
      expect_out("R3_R9 exc set", 1, 0, 0, 0, 0, 4'd3, 16'h0008, 1, 4'd7, 0, 32'h0BAD_0000);
   endtask

   task automatic t_rfw();
      wbase_i = 4'd6; wstart_i = 16'h00C0; saved_base_i = 4'd2;
      trap_pc_i = 32'h2000_0010; exc_mode_i = 1'b1; ovf_en_i = 1'b1;
      fire(OP_RFWO);
      expect_out("R6_R7 rfwo", 0, 0, 0, 1, 32'h2000_0010, 4'd2, 16'h0080, 0, 4'd2, 0, 32'h2000_0010);
      wstart_i = 16'h0080; saved_base_i = 4'd15; trap_pc_i = 32'h3000_0020;
      fire(OP_RFWU);
      expect_out("R6_R7 rfwu", 0, 0, 0, 1, 32'h3000_0020, 4'd15, 16'h00C0, 0, 4'd15, 0, 32'h3000_0020);
   endtask

   task automatic t_call();
      req_pc = 32'hC000_0FFE; req_call_inc = 2'd2;
      fire(OP_CALL);
      chk("R8 link c2", rsp_link, 32'h8000_1001);
      chk("R8 idx c2", 32'(rsp_link_idx), 32'd8);
      chk("R8 callinc c2", 32'(rsp_callinc), 32'd2);
      chk("R8 strobes c2", 32'({rsp_link_we, rsp_callinc_we}), 32'd3);
      req_pc = 32'h3FFF_FFFE; req_call_inc = 2'd3;
      fire(OP_CALL);
      chk("R8 link wrap c3", rsp_link, 32'hC000_0001);
      chk("R8 idx c3", 32'(rsp_link_idx), 32'd12);
   endtask

   task automatic t_idle();
      @(negedge clk);
      chk("R9 idle valid", 32'(rsp_valid), 32'd0);
      chk("R9 idle flags", 32'({rsp_illegal, rsp_underflow, rsp_jump, rsp_trap_we, rsp_link_we}), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_normal();
      t_underflow();
      t_illegal();
      t_rfw();
      t_call();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual expired expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule